// File: doc/BRIEF.md
# Conversion-Complete Interrupt Interval Generator

This block watches strobes from an analog-to-digital converter and decides when to raise a sticky "data available" flag. It also drives an interrupt request from that flag through an enable bit. A 2-bit interval select chooses when the flag is set. It can be set on every finished sample, at the end of every conversion sequence, or after a fixed number of samples (12 or 16 by default). A sample counter inside the block tracks the counted intervals. The counter restarts when a new sequence begins and after every counted flag event.

The flag stays set until software clears it with a one-cycle clear pulse, or until a new conversion sequence starts. If a set event arrives in the same cycle as a clear, the set event takes effect. The flag is held in a two-state machine. `FLG_IDLE` means no data is pending and `FLG_HELD` means data is available. The transition `SET` (IDLE→HELD) happens on a selected event. The transition `CLEAR` (HELD→IDLE) happens on a software clear or a sequence start when no set event is present. In every other case the machine keeps its state.

Top module: `adc_irq_gen`

## Requirements
- R1: With interval select 2'b00, every cycle with the sample-done strobe high makes the flag 1 in the following cycle.
- R2: With interval select 2'b01, a cycle with the end-of-sequence strobe high makes the flag 1 in the following cycle. A sample-done strobe alone does not set the flag in this mode.
- R3: With interval select 2'b10, the flag becomes 1 in the cycle after the SHORT_CNT-th (default 12) counted sample since the last sequence start or counted flag event. It stays 0 after SHORT_CNT-1 samples.
- R4: With interval select 2'b11, the flag becomes 1 in the cycle after the LONG_CNT-th (default 16) counted sample. It stays 0 after LONG_CNT-1 samples.
- R5: The interrupt output is 1 exactly when the flag is 1 and the enable input is 1. The enable input does not change the flag.
- R6: Once set, the flag stays 1 while no clear and no sequence start arrives. A software clear pulse with no set event makes it 0 in the following cycle.
- R7: A sequence-start pulse with no set event makes the flag 0 in the following cycle. It also restarts the sample count at zero. A sample strobe in the same cycle as the start is not counted.
- R8: A set event in the same cycle as a software clear or a sequence start leaves the flag 1 in the following cycle.
- R9: For a one-slot sequence, where the end-of-sequence strobe comes with every sample-done strobe, selects 2'b00 and 2'b01 set the flag on the same cycles.
- R10: After reset the flag and the interrupt output are 0, and the sample count is zero.
- R11: In the counted modes the count restarts after each flag event, so the next flag needs another full interval of samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_done_i | input | 1 | One-cycle strobe per finished sample |
| seq_end_i | input | 1 | One-cycle strobe when a sequence finishes its last slot |
| seq_start_i | input | 1 | One-cycle pulse when a new conversion sequence starts |
| sw_clr_i | input | 1 | One-cycle software clear of the flag |
| ivl_sel_i | input | 2 | Interval select: 00 sample, 01 sequence, 10 short count, 11 long count |
| irq_en_i | input | 1 | Interrupt enable |
| data_flag_o | output | 1 | Sticky data-available flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters, SHORT_CNT = 12 and LONG_CNT = 16. At these values both counted intervals are reached and checked one sample short of and exactly at their threshold, within a few dozen cycles. Because the four-bit counter sits at its maximum value in the long mode, the test also covers the wrap back to zero after a counted event. It also covers a restart mid-interval that is caused by a sequence start.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

    typedef enum logic [1:0] {
        IVL_SAMPLE = 2'b00,
        IVL_SEQ    = 2'b01,
        IVL_SHORT  = 2'b10,
        IVL_LONG   = 2'b11
    } ivl_sel_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_HELD = 1'b1
    } flag_state_e;

endpackage

// File: rtl/adc_irq_smpcnt.sv
module adc_irq_smpcnt
    import adc_irq_pkg::*;
#(
    parameter int SHORT_CNT = 12,
    parameter int LONG_CNT  = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     smp_done_i,
    input  logic     seq_start_i,
    input  ivl_sel_e ivl_sel_i,
    output logic     cnt_hit_o
);

    localparam int MAX_CNT = (LONG_CNT > SHORT_CNT) ? LONG_CNT : SHORT_CNT;
    localparam int CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CNT - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CNT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] last_idx;
    logic             counted;
    logic             at_last;

    always_comb begin
        counted  = (ivl_sel_i == IVL_SHORT) || (ivl_sel_i == IVL_LONG);
        last_idx = (ivl_sel_i == IVL_LONG) ? LONG_LAST : SHORT_LAST;
        at_last  = (cnt_q >= last_idx);
    end

    always_comb begin
        cnt_d = cnt_q;
        if (seq_start_i || !counted) begin
            cnt_d = '0;
        end else if (smp_done_i) begin
            cnt_d = at_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_hit_o = counted && smp_done_i && !seq_start_i && at_last;

endmodule

// File: rtl/adc_irq_evsel.sv
module adc_irq_evsel
    import adc_irq_pkg::*;
(
    input  ivl_sel_e ivl_sel_i,
    input  logic     smp_done_i,
    input  logic     seq_end_i,
    input  logic     cnt_hit_i,
    output logic     set_o
);

    always_comb begin
        unique case (ivl_sel_i)
            IVL_SAMPLE: set_o = smp_done_i;
            IVL_SEQ:    set_o = seq_end_i;
            IVL_SHORT,
            IVL_LONG:   set_o = cnt_hit_i;
            default:    set_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_irq_flagfsm.sv
module adc_irq_flagfsm
    import adc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    // Next-state: SET wins over CLEAR.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_i) state_d = FLG_HELD;
            FLG_HELD: if (clr_i && !set_i) state_d = FLG_IDLE;
            default:  state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag_o = (state_q == FLG_HELD);
        irq_o  = flag_o && irq_en_i;
    end

endmodule

// File: rtl/adc_irq_gen.sv
module adc_irq_gen
    import adc_irq_pkg::*;
#(
    parameter int SHORT_CNT = 12,
    parameter int LONG_CNT  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_done_i,
    input  logic       seq_end_i,
    input  logic       seq_start_i,
    input  logic       sw_clr_i,
    input  logic [1:0] ivl_sel_i,
    input  logic       irq_en_i,
    output logic       data_flag_o,
    output logic       irq_o
);

    ivl_sel_e sel;
    logic     cnt_hit;
    logic     set_evt;
    logic     clr_evt;

    assign sel     = ivl_sel_e'(ivl_sel_i);
    assign clr_evt = sw_clr_i || seq_start_i;

    adc_irq_smpcnt #(
        .SHORT_CNT (SHORT_CNT),
        .LONG_CNT  (LONG_CNT)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_done_i  (smp_done_i),
        .seq_start_i (seq_start_i),
        .ivl_sel_i   (sel),
        .cnt_hit_o   (cnt_hit)
    );

    adc_irq_evsel u_sel (
        .ivl_sel_i  (sel),
        .smp_done_i (smp_done_i),
        .seq_end_i  (seq_end_i),
        .cnt_hit_i  (cnt_hit),
        .set_o      (set_evt)
    );

    adc_irq_flagfsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_evt),
        .clr_i    (clr_evt),
        .irq_en_i (irq_en_i),
        .flag_o   (data_flag_o),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/adc_irq_chk.sv
module adc_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_done_i,
    input logic       seq_end_i,
    input logic       seq_start_i,
    input logic       sw_clr_i,
    input logic [1:0] ivl_sel_i,
    input logic       irq_en_i,
    input logic       data_flag_o,
    input logic       irq_o
);

    a_r1_sample_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_sel_i == 2'b00 && smp_done_i) |=> data_flag_o);

    a_r2_seq_end_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_sel_i == 2'b01 && seq_end_i) |=> data_flag_o);

    a_r2_sample_alone_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_sel_i == 2'b01 && !seq_end_i && !data_flag_o) |=> !data_flag_o);

    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (data_flag_o && irq_en_i));

    a_r5_irq_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (data_flag_o && irq_en_i) |-> irq_o);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (data_flag_o && !sw_clr_i && !seq_start_i) |=> data_flag_o);

    a_r6_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_i && ivl_sel_i == 2'b01 && !seq_end_i) |=> !data_flag_o);

    a_r7_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start_i && ivl_sel_i == 2'b01 && !seq_end_i) |=> !data_flag_o);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_sel_i == 2'b00 && smp_done_i && (sw_clr_i || seq_start_i)) |=> data_flag_o);

    a_r3_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_flag_o) |-> $past(smp_done_i || seq_end_i));

endmodule

bind adc_irq_gen adc_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_done_i  (smp_done_i),
    .seq_end_i   (seq_end_i),
    .seq_start_i (seq_start_i),
    .sw_clr_i    (sw_clr_i),
    .ivl_sel_i   (ivl_sel_i),
    .irq_en_i    (irq_en_i),
    .data_flag_o (data_flag_o),
    .irq_o       (irq_o)
);

// File: tb/tb_adc_irq_gen.sv
module tb_adc_irq_gen;

    localparam int CLK_PERIOD = 10;
    localparam int SHORT_CNT  = 12;
    localparam int LONG_CNT   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_done_i = 1'b0;
    logic       seq_end_i = 1'b0;
    logic       seq_start_i = 1'b0;
    logic       sw_clr_i = 1'b0;
    logic [1:0] ivl_sel_i = 2'b00;
    logic       irq_en_i = 1'b0;
    logic       data_flag_o;
    logic       irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_irq_gen #(.SHORT_CNT(SHORT_CNT), .LONG_CNT(LONG_CNT)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_done_i  (smp_done_i),
        .seq_end_i   (seq_end_i),
        .seq_start_i (seq_start_i),
        .sw_clr_i    (sw_clr_i),
        .ivl_sel_i   (ivl_sel_i),
        .irq_en_i    (irq_en_i),
        .data_flag_o (data_flag_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Drive one cycle of strobes at a falling edge; return at the next falling edge.
    task automatic step(input logic smp, input logic send, input logic start, input logic clr);
        smp_done_i  = smp;
        seq_end_i   = send;
        seq_start_i = start;
        sw_clr_i    = clr;
        @(negedge clk);
        smp_done_i  = 1'b0;
        seq_end_i   = 1'b0;
        seq_start_i = 1'b0;
        sw_clr_i    = 1'b0;
    endtask

    task automatic samples(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R10 flag after reset", data_flag_o, 1'b0);
        chk("R10 irq after reset", irq_o, 1'b0);
        ivl_sel_i = 2'b10;
        samples(SHORT_CNT - 1);
        chk("R10 count starts at zero", data_flag_o, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_per_sample();
        ivl_sel_i = 2'b00;
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R1 no sample no flag", data_flag_o, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R1 sample sets flag", data_flag_o, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R1 second sample sets flag", data_flag_o, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_per_seq();
        ivl_sel_i = 2'b01;
        step(1'b0, 1'b0, 1'b1, 1'b0);
        samples(3);
        chk("R2 samples alone no flag", data_flag_o, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R2 end of sequence sets flag", data_flag_o, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_one_slot();
        logic f01;
        logic f00;
        ivl_sel_i = 2'b01;
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        f01 = data_flag_o;
        step(1'b0, 1'b0, 1'b0, 1'b1);
        ivl_sel_i = 2'b00;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        f00 = data_flag_o;
        chk("R9 sel01 one-slot flags", f01, 1'b1);
        chk("R9 sel00 matches sel01", f00, f01);
        step(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_short();
        ivl_sel_i = 2'b10;
        step(1'b0, 1'b0, 1'b1, 1'b0);
        samples(SHORT_CNT - 1);
        chk("R3 one short of interval", data_flag_o, 1'b0);
        samples(1);
        chk("R3 flag at short interval", data_flag_o, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        samples(SHORT_CNT - 1);
        chk("R11 count restarted after event", data_flag_o, 1'b0);
        samples(1);
        chk("R11 second interval flags", data_flag_o, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_long();
        ivl_sel_i = 2'b11;
        step(1'b0, 1'b0, 1'b1, 1'b0);
        samples(LONG_CNT - 1);
        chk("R4 one short of interval", data_flag_o, 1'b0);
        samples(1);
        chk("R4 flag at long interval", data_flag_o, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        samples(LONG_CNT - 1);
        chk("R4 wrap then one short", data_flag_o, 1'b0);
        samples(1);
        chk("R4 wrap then flag", data_flag_o, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_gate();
        ivl_sel_i = 2'b00;
        irq_en_i  = 1'b1;
        #1;
        chk("R5 enabled but no flag", irq_o, 1'b0);
        irq_en_i = 1'b0;
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 enable does not block flag", data_flag_o, 1'b1);
        chk("R5 flag but disabled", irq_o, 1'b0);
        irq_en_i = 1'b1;
        #1;
        chk("R5 flag and enabled", irq_o, 1'b1);
        @(negedge clk);
        irq_en_i = 1'b0;
        #1;
        chk("R5 enable dropped", irq_o, 1'b0);
        chk("R5 flag kept on disable", data_flag_o, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_sticky();
        ivl_sel_i = 2'b00;
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk("R6 flag sticky", data_flag_o, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6 software clear", data_flag_o, 1'b0);
    endtask

    task automatic t_start();
        ivl_sel_i = 2'b00;
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7 start clears flag", data_flag_o, 1'b0);
        ivl_sel_i = 2'b10;
        samples(5);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        samples(SHORT_CNT - 1);
        chk("R7 start restarts count, coincident sample ignored", data_flag_o, 1'b0);
        samples(1);
        chk("R7 full interval after start", data_flag_o, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_set_wins();
        ivl_sel_i = 2'b00;
        step(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R8 set beats software clear", data_flag_o, 1'b1);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R8 set beats sequence start", data_flag_o, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_per_sample();
        t_per_seq();
        t_one_slot();
        t_short();
        t_long();
        t_gate();
        t_sticky();
        t_start();
        t_set_wins();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule